// File: doc/BRIEF.md
# DDR2 Command Timing Gate

The block holds a packed, software-programmable word of DDR2 AC-timing spacings and uses it to decide, cycle by cycle, whether a command offered by a memory scheduler may go out. Every spacing is stored as a cycle count minus one, so a field value of N keeps the guarded command back for N+1 memory-clock cycles. The scheduler presents one command at a time with a bank index. The block answers in the same cycle with a grant when every spacing that applies has run out. A granted command restarts its own spacing counters at the next clock edge. A request that is refused is held by the scheduler until it is granted.

The timing word can only be written while an unlock input is high. Two further checks run on every accepted write. A write that changes the write-recovery field while the controller is enabled produces a one-cycle request to re-initialise the memory. A write that leaves the activate-to-precharge field below the activate-to-read/write field sets a sticky configuration-error flag. The block tracks four banks, each with its own down-counters. Three counters are shared by all banks: refresh/precharge recovery, activate-to-activate across banks, and write-to-read turnaround.

Top module: `ddr_cmd_timing_gate`

## Requirements
- R1: After reset the timing word reads 0x7FFF_FFFB, and `reinit_req` and `cfg_err` are 0.
- R2: The word is laid out, from the top, as refresh cycle [31:25], precharge [24:22], activate-to-read/write [21:19], write recovery [18:16], activate-to-precharge [15:11], activate-to-activate same bank [10:6], activate-to-activate other bank [5:3], reserved [2], write-to-read [1:0]. The reserved bit always reads 0. An accepted write is readable on `cfg_rdata` in the next cycle.
- R3: While `tim_unlock` is 0, a write leaves the stored word unchanged.
- R4: `cmd_grant` is combinational and is 1 only when `cmd_valid` is 1 and `cmd_op` is a legal code: 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE, 4 REFRESH, 5 LOAD MODE. Codes 6 and 7 are never granted. LOAD MODE has no spacing of its own.
- R5: After a granted REFRESH or LOAD MODE, REFRESH and ACTIVATE to any bank are refused for refresh-cycle field + 1 cycles.
- R6: After a granted PRECHARGE, REFRESH and ACTIVATE to any bank are refused for precharge field + 1 cycles.
- R7: After a granted ACTIVATE to bank b, READ and WRITE to b are refused for activate-to-read/write field + 1 cycles. Other banks are not affected.
- R8: After a granted ACTIVATE to bank b, PRECHARGE to b is refused for activate-to-precharge field + 1 cycles, and ACTIVATE to b for activate-to-activate-same-bank field + 1 cycles.
- R9: After a granted ACTIVATE, ACTIVATE to any bank is refused for activate-to-activate-other-bank field + 1 cycles.
- R10: After `wr_burst_done` for bank b, PRECHARGE to b is refused for write-recovery field + 1 cycles.
- R11: After a granted WRITE, READ to any bank is refused for write-to-read field + 1 cycles.
- R12: An accepted write that changes the write-recovery field while `ctrl_en` is 1 makes `reinit_req` high for exactly the next cycle. No pulse follows when the field is unchanged or when `ctrl_en` is 0.
- R13: An accepted write whose activate-to-precharge field is below its activate-to-read/write field sets `cfg_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Stored timing word |
| tim_unlock | input | 1 | 1 allows timing word writes |
| ctrl_en | input | 1 | Controller enabled; qualifies the re-initialisation request |
| reinit_req | output | 1 | One-cycle memory re-initialisation request |
| cfg_err | output | 1 | Sticky flag: activate-to-precharge below activate-to-read/write |
| cmd_valid | input | 1 | Command request present |
| cmd_op | input | 3 | Command code (see R4) |
| cmd_bank | input | 2 | Target bank |
| cmd_grant | output | 1 | Command may issue this cycle |
| wr_burst_done | input | 1 | Last write data transfer to a bank |
| wr_burst_bank | input | 2 | Bank of that last transfer |

## Verification
Each spacing is tried with a pair of commands: a granted opener, then the guarded command offered every cycle until it is granted. The check therefore fixes the exact cycle of release, and an off-by-one in the minus-one encoding shows up. Pairs that cross banks show that per-bank counters do not leak into other banks, and that the shared counters do reach every bank. The register checks cover a locked write and a write that sets the reserved bit. The re-initialisation pulse is tried with the controller disabled, with the write-recovery field changed, and with it left unchanged. The error flag is set by one write and then checked again after a clean write.

// File: rtl/ddrtg_pkg.sv
package ddrtg_pkg;

  localparam int WORD_W = 32;

  // field widths
  localparam int RFC_W = 7;
  localparam int RP_W  = 3;
  localparam int RCD_W = 3;
  localparam int WR_W  = 3;
  localparam int RAS_W = 5;
  localparam int RC_W  = 5;
  localparam int RRD_W = 3;
  localparam int WTR_W = 2;

  localparam int RSVD_BIT = 2;

  localparam logic [WORD_W-1:0] TIM_RESET = 32'h7FFF_FFFB;
  localparam logic [WORD_W-1:0] TIM_WMASK = ~(32'h1 << RSVD_BIT);

  typedef enum logic [2:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_REF = 3'd4,
    OP_LMR = 3'd5
  } cmd_op_e;

  typedef struct packed {
    logic [RFC_W-1:0] t_rfc;
    logic [RP_W-1:0]  t_rp;
    logic [RCD_W-1:0] t_rcd;
    logic [WR_W-1:0]  t_wr;
    logic [RAS_W-1:0] t_ras;
    logic [RC_W-1:0]  t_rc;
    logic [RRD_W-1:0] t_rrd;
    logic             rsvd;
    logic [WTR_W-1:0] t_wtr;
  } tim_fields_t;

endpackage

// File: rtl/ddrtg_downcnt.sv
module ddrtg_downcnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (busy)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ddrtg_timreg.sv
module ddrtg_timreg
  import ddrtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              unlock,
  input  logic              ctrl_en,
  output logic [WORD_W-1:0] word,
  output logic              reinit_pulse,
  output logic              err_flag
);

  logic [WORD_W-1:0] word_q, word_d;
  logic              reinit_q, reinit_d;
  logic              err_q, err_d;
  logic              accept;
  tim_fields_t       cur_f, new_f;

  assign accept = wr_en & unlock;
  assign cur_f  = tim_fields_t'(word_q);
  assign new_f  = tim_fields_t'(wr_data & TIM_WMASK);

  always_comb begin
    word_d   = word_q;
    reinit_d = 1'b0;
    err_d    = err_q;
    if (accept) begin
      word_d   = wr_data & TIM_WMASK;
      reinit_d = ctrl_en & (new_f.t_wr != cur_f.t_wr);
      if ({2'b00, new_f.t_rcd} > new_f.t_ras)
        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= TIM_RESET;
      reinit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      reinit_q <= reinit_d;
      if (accept) begin
        word_q <= word_d;
        err_q  <= err_d;
      end
    end
  end

  assign word         = word_q;
  assign reinit_pulse = reinit_q;
  assign err_flag     = err_q;

endmodule

// File: rtl/ddrtg_bank_track.sv
module ddrtg_bank_track
  import ddrtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_ld,
  input  logic             wlast_ld,
  input  logic [RCD_W-1:0] t_rcd,
  input  logic [RAS_W-1:0] t_ras,
  input  logic [RC_W-1:0]  t_rc,
  input  logic [WR_W-1:0]  t_wr,
  output logic             rw_blk,
  output logic             pre_blk,
  output logic             act_blk
);

  logic ras_busy, wr_busy;

  ddrtg_downcnt #(.W(RCD_W)) i_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(t_rcd), .busy(rw_blk)
  );

  ddrtg_downcnt #(.W(RAS_W)) i_ras (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(t_ras), .busy(ras_busy)
  );

  ddrtg_downcnt #(.W(RC_W)) i_rc (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(t_rc), .busy(act_blk)
  );

  ddrtg_downcnt #(.W(WR_W)) i_wrec (
    .clk(clk), .rst_n(rst_n), .load(wlast_ld), .load_val(t_wr), .busy(wr_busy)
  );

  assign pre_blk = ras_busy | wr_busy;

endmodule

// File: rtl/ddr_cmd_timing_gate.sv
module ddr_cmd_timing_gate
  import ddrtg_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              tim_unlock,
  input  logic              ctrl_en,
  output logic              reinit_req,
  output logic              cfg_err,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_grant,
  input  logic              wr_burst_done,
  input  logic [BANK_W-1:0] wr_burst_bank
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [WORD_W-1:0] word;
  tim_fields_t       tim;

  ddrtg_timreg i_timreg (
    .clk(clk), .rst_n(rst_n_int), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .unlock(tim_unlock), .ctrl_en(ctrl_en), .word(word),
    .reinit_pulse(reinit_req), .err_flag(cfg_err)
  );

  assign tim       = tim_fields_t'(word);
  assign cfg_rdata = word;

  // command decode
  logic is_act, is_rd, is_wr, is_pre, is_ref, is_lmr;
  always_comb begin
    is_act = 1'b0; is_rd = 1'b0; is_wr = 1'b0;
    is_pre = 1'b0; is_ref = 1'b0; is_lmr = 1'b0;
    case (cmd_op_e'(cmd_op))
      OP_ACT:  is_act = 1'b1;
      OP_RD:   is_rd  = 1'b1;
      OP_WR:   is_wr  = 1'b1;
      OP_PRE:  is_pre = 1'b1;
      OP_REF:  is_ref = 1'b1;
      OP_LMR:  is_lmr = 1'b1;
      default: ;
    endcase
  end

  // per-bank trackers
  logic [NUM_BANKS-1:0] bk_rw_blk, bk_pre_blk, bk_act_blk;
  logic [NUM_BANKS-1:0] bk_act_ld, bk_wlast_ld;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bk_act_ld[b]   = cmd_grant & is_act & (cmd_bank == BANK_W'(b));
      assign bk_wlast_ld[b] = wr_burst_done & (wr_burst_bank == BANK_W'(b));

      ddrtg_bank_track i_bank (
        .clk(clk), .rst_n(rst_n_int),
        .act_ld(bk_act_ld[b]), .wlast_ld(bk_wlast_ld[b]),
        .t_rcd(tim.t_rcd), .t_ras(tim.t_ras), .t_rc(tim.t_rc), .t_wr(tim.t_wr),
        .rw_blk(bk_rw_blk[b]), .pre_blk(bk_pre_blk[b]), .act_blk(bk_act_blk[b])
      );
    end
  endgenerate

  // shared counters
  logic rfc_busy, rp_busy, rrd_busy, wtr_busy;

  ddrtg_downcnt #(.W(RFC_W)) i_rfc (
    .clk(clk), .rst_n(rst_n_int), .load(cmd_grant & (is_ref | is_lmr)),
    .load_val(tim.t_rfc), .busy(rfc_busy)
  );

  ddrtg_downcnt #(.W(RP_W)) i_rp (
    .clk(clk), .rst_n(rst_n_int), .load(cmd_grant & is_pre),
    .load_val(tim.t_rp), .busy(rp_busy)
  );

  ddrtg_downcnt #(.W(RRD_W)) i_rrd (
    .clk(clk), .rst_n(rst_n_int), .load(cmd_grant & is_act),
    .load_val(tim.t_rrd), .busy(rrd_busy)
  );

  ddrtg_downcnt #(.W(WTR_W)) i_wtr (
    .clk(clk), .rst_n(rst_n_int), .load(cmd_grant & is_wr),
    .load_val(tim.t_wtr), .busy(wtr_busy)
  );

  // grant
  logic clear_to_go;
  always_comb begin
    clear_to_go = 1'b0;
    if (is_act)
      clear_to_go = !rfc_busy && !rp_busy && !rrd_busy && !bk_act_blk[cmd_bank];
    else if (is_rd)
      clear_to_go = !bk_rw_blk[cmd_bank] && !wtr_busy;
    else if (is_wr)
      clear_to_go = !bk_rw_blk[cmd_bank];
    else if (is_pre)
      clear_to_go = !bk_pre_blk[cmd_bank];
    else if (is_ref)
      clear_to_go = !rfc_busy && !rp_busy;
    else if (is_lmr)
      clear_to_go = 1'b1;
  end

  assign cmd_grant = cmd_valid & clear_to_go;

endmodule

// File: rtl/ddrtg_checker.sv
module ddrtg_checker
  import ddrtg_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              tim_unlock,
  input logic              ctrl_en,
  input logic              reinit_req,
  input logic              cfg_err,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              cmd_grant
);

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[RSVD_BIT] == 1'b0);

  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !tim_unlock) |=> $stable(cfg_rdata));

  a_r4_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_grant |-> (cmd_valid && (cmd_op <= 3'd5)));

  a_r5_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_grant && (cmd_op == 3'd4 || cmd_op == 3'd5) && cfg_rdata[31:25] != '0)
    |=> !(cmd_grant && (cmd_op == 3'd4 || cmd_op == 3'd0)));

  a_r9_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_grant && cmd_op == 3'd0 && cfg_rdata[5:3] != '0)
    |=> !(cmd_grant && cmd_op == 3'd0));

  a_r12_reinit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> $past(cfg_we && tim_unlock && ctrl_en));

  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind ddr_cmd_timing_gate ddrtg_checker #(.BANK_W(BANK_W)) i_ddrtg_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .tim_unlock(tim_unlock), .ctrl_en(ctrl_en), .reinit_req(reinit_req),
  .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_grant(cmd_grant)
);

// File: tb/test_ddr_cmd_timing_gate.sv
module test_ddr_cmd_timing_gate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tim_unlock;
  logic        ctrl_en;
  logic        reinit_req;
  logic        cfg_err;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic        cmd_grant;
  logic        wr_burst_done;
  logic [1:0]  wr_burst_bank;

  always #4 clk = ~clk;

  ddr_cmd_timing_gate i_ddr_cmd_timing_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tim_unlock(tim_unlock), .ctrl_en(ctrl_en),
    .reinit_req(reinit_req), .cfg_err(cfg_err), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_grant(cmd_grant),
    .wr_burst_done(wr_burst_done), .wr_burst_bank(wr_burst_bank)
  );

  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, PRE = 3'd3,
                         REF = 3'd4, LMR = 3'd5, WLAST = 3'd7;
  localparam int K_GRANT = 0, K_RDATA = 1, K_REINIT = 2, K_ERR = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_GRANT:  act = {31'd0, cmd_grant};
        K_RDATA:  act = cfg_rdata;
        K_REINIT: act = {31'd0, reinit_req};
        default:  act = {31'd0, cfg_err};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] e, input string tag);
    exp_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    cfg_we        = 1'b0;
    cmd_valid     = 1'b0;
    wr_burst_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic look(input int kind, input logic [31:0] e, input string tag);
    cyc();
    push(kind, e, tag);
  endtask

  task automatic probe(input logic [2:0] op, input logic [1:0] bk,
                       input logic e, input string tag);
    cyc();
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bank  = bk;
    push(K_GRANT, {31'd0, e}, tag);
  endtask

  task automatic reg_write(input logic [31:0] d);
    cyc();
    cfg_we    = 1'b1;
    cfg_wdata = d;
  endtask

  // opener, then the guarded command every cycle until released
  task automatic spacing(input logic [2:0] op_a, input logic [1:0] bk_a,
                         input logic [2:0] op_b, input logic [1:0] bk_b,
                         input int n, input string tag);
    if (op_a == WLAST) begin
      cyc();
      wr_burst_done = 1'b1;
      wr_burst_bank = bk_a;
    end else begin
      probe(op_a, bk_a, 1'b1, {tag, " opener"});
    end
    for (int i = 0; i < n; i++) probe(op_b, bk_b, 1'b0, {tag, " held"});
    probe(op_b, bk_b, 1'b1, {tag, " released"});
    idle(10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; tim_unlock = 1'b0;
    ctrl_en = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0;
    wr_burst_done = 1'b0; wr_burst_bank = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    // R1 reset state
    look(K_RDATA, 32'h7FFF_FFFB, "R1 word");
    push(K_REINIT, 0, "R1 reinit");
    push(K_ERR, 0, "R1 err");
    push(K_GRANT, 0, "R4 no valid no grant");

    // R4 / R5 with the reset refresh spacing
    probe(LMR, 0, 1'b1, "R4 load mode free");
    probe(REF, 0, 1'b0, "R5 default refresh spacing");

    // R2 program small spacings, reserved bit set in write data
    tim_unlock = 1'b1;
    reg_write(32'h0A93_218D);
    look(K_RDATA, 32'h0A93_2189, "R2 readback");
    push(K_REINIT, 0, "R12 enable low no pulse");

    // R3 locked write
    tim_unlock = 1'b0;
    reg_write(32'hFFFF_FFFF);
    look(K_RDATA, 32'h0A93_2189, "R3 locked");
    tim_unlock = 1'b1;

    // R4 illegal codes
    probe(3'd6, 0, 1'b0, "R4 code 6");
    probe(3'd7, 1, 1'b0, "R4 code 7");
    idle(70);

    spacing(LMR, 0, REF, 0, 5, "R5 lmr-ref");
    spacing(REF, 0, ACT, 2, 5, "R5 ref-act");
    spacing(PRE, 1, REF, 0, 2, "R6 pre-ref");
    spacing(PRE, 1, ACT, 3, 2, "R6 pre-act");
    spacing(ACT, 0, RD, 0, 2, "R7 act-rd");
    spacing(ACT, 0, WR, 0, 2, "R7 act-wr");
    probe(ACT, 0, 1'b1, "R7 opener");
    probe(RD, 1, 1'b1, "R7 other bank free");
    idle(10);
    spacing(ACT, 0, PRE, 0, 4, "R8 act-pre");
    spacing(ACT, 0, ACT, 0, 6, "R8 act-act same");
    spacing(ACT, 0, ACT, 1, 1, "R9 act-act other");
    spacing(WLAST, 2, PRE, 2, 3, "R10 wlast-pre");
    spacing(WR, 0, RD, 1, 1, "R11 wr-rd");

    // R12 re-initialisation pulse
    ctrl_en = 1'b1;
    reg_write(32'h0A95_218D);
    look(K_REINIT, 1, "R12 pulse");
    push(K_RDATA, 32'h0A95_2189, "R12 new word");
    look(K_REINIT, 0, "R12 single cycle");
    reg_write(32'h0A55_2189);
    look(K_REINIT, 0, "R12 unchanged field");
    ctrl_en = 1'b0;

    // R13 configuration error
    push(K_ERR, 0, "R13 clean");
    reg_write(32'h0A55_0989);
    look(K_ERR, 1, "R13 set");
    reg_write(32'h0A55_2189);
    look(K_ERR, 1, "R13 sticky");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule